// File: doc/BRIEF.md
# Interleaved Two-Phase Buck PWM Generator

This block drives the gates of two synchronous buck converters from one shared counter. Channel "pri" feeds the memory supply and channel "sec" feeds the core supply. Each channel takes an enable and a duty word. The duty word gives the number of clock cycles per normal period for which the high-side switch should conduct. Each channel drives a complementary pair of gate controls. Both gates of a pair are low for a guard interval around every switching edge.

Both channels share one switching period of `PERIOD` clock cycles. The secondary period starts half a period after the primary period, so the two input-current pulses interleave. When `stby` is high, the primary runs at half the period, which is twice the frequency. The duty word is then halved, so the conducting fraction stays the same. The secondary is held off while `stby` is high.

Top module: `dual_phase_pwm`

## Requirements
- R1: In normal mode, with an enabled channel and a duty `d` where `DEAD < d < PERIOD-DEAD`, the channel's high-side output is high for `d-DEAD` cycles and its low-side output for `PERIOD-d-DEAD` cycles in every window of `PERIOD` cycles. Each window holds exactly one high-side rising edge.
- R2: When `stby`=1, the primary period is `PERIOD/2` cycles and the effective duty is `floor(d/2)`. A window of `PERIOD` cycles then holds two high-side pulses of `floor(d/2)-DEAD` cycles each.
- R3: While `stby`=1, both secondary outputs are low, whatever `sec_en` and `sec_duty` are.
- R4: While a channel's enable is low, both of its outputs are low.
- R5: The high-side and low-side outputs of a channel are never high in the same cycle. Every switching edge is separated from the opposite gate's edge by `DEAD` cycles in which both are low.
- R6: A duty of 0 holds the high side low and the low side high for whole periods. A duty of `PERIOD` holds the high side high for whole periods, and the low side low.
- R7: A duty word greater than `PERIOD` acts as `PERIOD`.
- R8: With equal duties in normal mode, the secondary high side rises `PERIOD/2` cycles after the primary high side.
- R9: The duty word is sampled only at the start of the channel's period. A change during a pulse leaves that pulse's length unchanged and takes effect in the next period.
- R10: While `rst` is high, all four gate outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| stby | input | 1 | 1 selects standby mode: primary at double rate, secondary off |
| pri_en | input | 1 | Primary channel enable |
| sec_en | input | 1 | Secondary channel enable |
| pri_duty | input | $clog2(PERIOD+1) | Primary high-side on-time, in cycles per normal period |
| sec_duty | input | $clog2(PERIOD+1) | Secondary high-side on-time, in cycles per normal period |
| pri_hs | output | 1 | Primary high-side gate control |
| pri_ls | output | 1 | Primary low-side gate control |
| sec_hs | output | 1 | Secondary high-side gate control |
| sec_ls | output | 1 | Secondary low-side gate control |

## Verification
A duty word is taken at the next period start of its channel. The high side then rises `DEAD+1` cycles after that start, because one register follows the modulator and the guard count comes after it. Enable and mode gate the outputs in the same cycle. The bench waits three full periods after each change of duty or mode, then counts high, low and rising-edge cycles over a window of exactly one normal period. These counts do not depend on where the window starts. The phase test and the mid-pulse duty test time their counts from an observed rising edge, so they do not rely on absolute cycle numbers.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_STBY = 1'b1
    } pwr_mode_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    function automatic logic [31:0] clamp_on(input logic [31:0] d, input logic [31:0] lim);
        return (d > lim) ? lim : d;
    endfunction

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
    parameter int PERIOD = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic stby,
    output logic pri_start,
    output logic sec_start
);
    localparam int HALF = PERIOD / 2;
    localparam int CW   = $clog2(PERIOD);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == CW'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        sec_start = (cnt == CW'(HALF));
        pri_start = (cnt == '0) || (stby && sec_start);
    end
endmodule

// File: rtl/dpwm_modulator.sv
module dpwm_modulator #(
    parameter int PERIOD = 200,
    parameter int DW     = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          half,
    input  logic [DW-1:0] duty,
    output logic          raw
);
    logic [DW-1:0] left;
    logic [DW-1:0] clamped;
    logic [DW-1:0] eff;

    always_comb begin
        clamped = DW'(dpwm_pkg::clamp_on(32'(duty), 32'(PERIOD)));
        eff     = half ? (clamped >> 1) : clamped;
        raw     = (left != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            left <= '0;
        else if (start)
            left <= eff;
        else if (left != '0)
            left <= left - 1'b1;
    end
endmodule

// File: rtl/dpwm_deadband.sv
module dpwm_deadband
    import dpwm_pkg::*;
#(
    parameter int DEAD = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       raw,
    output gate_pair_t gate
);
    localparam int SW = $clog2(DEAD + 1);

    logic          r;
    logic [SW-1:0] settle;
    logic          ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            r      <= 1'b0;
            settle <= '0;
        end else begin
            r <= raw;
            if (raw != r)
                settle <= '0;
            else if (settle != SW'(DEAD))
                settle <= settle + 1'b1;
        end
    end

    always_comb begin
        ready   = (settle == SW'(DEAD));
        gate.hs = en && r && ready;
        gate.ls = en && !r && ready;
    end
endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm
    import dpwm_pkg::*;
#(
    parameter int PERIOD = 200,
    parameter int DEAD   = 10,
    localparam int DW    = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stby,
    input  logic          pri_en,
    input  logic          sec_en,
    input  logic [DW-1:0] pri_duty,
    input  logic [DW-1:0] sec_duty,
    output logic          pri_hs,
    output logic          pri_ls,
    output logic          sec_hs,
    output logic          sec_ls
);
    localparam int NCH = 2;

    pwr_mode_e     mode;
    logic          pri_start, sec_start;
    logic [NCH-1:0] ch_start, ch_half, ch_en, ch_raw;
    logic [DW-1:0] ch_duty [NCH];
    gate_pair_t    ch_gate [NCH];

    always_comb begin
        mode       = pwr_mode_e'(stby);
        ch_start   = {sec_start, pri_start};
        ch_half    = {1'b0, (mode == MODE_STBY)};
        ch_en      = {sec_en && (mode == MODE_RUN), pri_en};
        ch_duty[0] = pri_duty;
        ch_duty[1] = sec_duty;
    end

    dpwm_timebase #(.PERIOD(PERIOD)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .stby      (mode == MODE_STBY),
        .pri_start (pri_start),
        .sec_start (sec_start)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dpwm_modulator #(.PERIOD(PERIOD), .DW(DW)) u_mod (
            .clk   (clk),
            .rst   (rst),
            .start (ch_start[c]),
            .half  (ch_half[c]),
            .duty  (ch_duty[c]),
            .raw   (ch_raw[c])
        );
        dpwm_deadband #(.DEAD(DEAD)) u_db (
            .clk  (clk),
            .rst  (rst),
            .en   (ch_en[c]),
            .raw  (ch_raw[c]),
            .gate (ch_gate[c])
        );
    end

    always_comb begin
        pri_hs = ch_gate[0].hs;
        pri_ls = ch_gate[0].ls;
        sec_hs = ch_gate[1].hs;
        sec_ls = ch_gate[1].ls;
    end
endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker (
    input logic clk,
    input logic rst,
    input logic stby,
    input logic pri_en,
    input logic pri_hs,
    input logic pri_ls,
    input logic sec_hs,
    input logic sec_ls
);
    AST_PRI_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(pri_hs && pri_ls)); // R5
    AST_SEC_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(sec_hs && sec_ls)); // R5
    AST_PRI_HS_GAP: assert property (@(posedge clk) disable iff (rst) $rose(pri_hs) |-> !$past(pri_ls)); // R5
    AST_SEC_HS_GAP: assert property (@(posedge clk) disable iff (rst) $rose(sec_hs) |-> !$past(sec_ls)); // R5
    AST_SEC_OFF_STBY: assert property (@(posedge clk) disable iff (rst) stby |-> (!sec_hs && !sec_ls)); // R3
    AST_PRI_OFF_DIS: assert property (@(posedge clk) disable iff (rst) !pri_en |-> (!pri_hs && !pri_ls)); // R4
endmodule

bind dual_phase_pwm dpwm_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .stby   (stby),
    .pri_en (pri_en),
    .pri_hs (pri_hs),
    .pri_ls (pri_ls),
    .sec_hs (sec_hs),
    .sec_ls (sec_ls)
);

// File: tb/tb_dual_phase_pwm.sv
module tb_dual_phase_pwm;
    localparam int P  = 20;
    localparam int D  = 2;
    localparam int H  = P / 2;
    localparam int DW = $clog2(P + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, stby, pri_en, sec_en;
    logic [DW-1:0] pri_duty, sec_duty;
    logic pri_hs, pri_ls, sec_hs, sec_ls;

    dual_phase_pwm #(.PERIOD(P), .DEAD(D)) dut (
        .clk(clk), .rst(rst), .stby(stby), .pri_en(pri_en), .sec_en(sec_en),
        .pri_duty(pri_duty), .sec_duty(sec_duty),
        .pri_hs(pri_hs), .pri_ls(pri_ls), .sec_hs(sec_hs), .sec_ls(sec_ls)
    );

    typedef struct packed {
        logic       stby, enp, ens;
        logic [7:0] dp, ds, phi, plo, prise, shi, slo;
    } vec_t;

    // expected counts per window of P cycles, P=20, DEAD=2
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b1, 1'b1, 8'd10, 8'd6,  8'd8,  8'd8,  8'd1, 8'd4,  8'd12}, // R1
        '{1'b0, 1'b1, 1'b1, 8'd0,  8'd20, 8'd0,  8'd20, 8'd0, 8'd20, 8'd0 }, // R6
        '{1'b1, 1'b1, 1'b1, 8'd12, 8'd8,  8'd8,  8'd4,  8'd2, 8'd0,  8'd0 }, // R2 R3
        '{1'b0, 1'b0, 1'b1, 8'd8,  8'd31, 8'd0,  8'd0,  8'd0, 8'd20, 8'd0 }, // R4 R7
        '{1'b1, 1'b1, 1'b0, 8'd20, 8'd5,  8'd20, 8'd0,  8'd0, 8'd0,  8'd0 }, // R2 R6
        '{1'b0, 1'b1, 1'b1, 8'd15, 8'd5,  8'd13, 8'd3,  8'd1, 8'd3,  8'd13}  // R1
    };

    int tests = 0;
    int fails = 0;
    int ovl   = 0;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk)
        if (!rst && ((pri_hs && pri_ls) || (sec_hs && sec_ls))) ovl++;

    task automatic measure(output int phi, output int plo, output int prise,
                           output int shi, output int slo);
        logic pv;
        phi = 0; plo = 0; prise = 0; shi = 0; slo = 0;
        pv = pri_hs;
        for (int i = 0; i < P; i++) begin
            @(negedge clk);
            if (pri_hs) phi++;
            if (pri_ls) plo++;
            if (pri_hs && !pv) prise++;
            if (sec_hs) shi++;
            if (sec_ls) slo++;
            pv = pri_hs;
        end
    endtask

    task automatic wait_pri_rise(output bit seen);
        logic pv;
        seen = 0;
        pv = pri_hs;
        for (int i = 0; i < 4 * P; i++) begin
            @(negedge clk);
            if (pri_hs && !pv) begin
                seen = 1;
                break;
            end
            pv = pri_hs;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int phi, plo, prise, shi, slo, n, len;
        bit seen;
        rst = 1'b1; stby = 1'b0; pri_en = 1'b1; sec_en = 1'b1;
        pri_duty = DW'(10); sec_duty = DW'(10);
        repeat (4) @(negedge clk);
        chk("R10 reset gates", {pri_hs, pri_ls, sec_hs, sec_ls}, 0);

        @(negedge clk);
        pri_en = 1'b0; sec_en = 1'b0; rst = 1'b0;
        repeat (3 * P) @(negedge clk);
        measure(phi, plo, prise, shi, slo);
        chk("R4 disabled pri", phi + plo, 0);
        chk("R4 disabled sec", shi + slo, 0);

        for (int v = 0; v < 6; v++) begin
            stby = VECS[v].stby; pri_en = VECS[v].enp; sec_en = VECS[v].ens;
            pri_duty = DW'(VECS[v].dp); sec_duty = DW'(VECS[v].ds);
            repeat (3 * P) @(negedge clk);
            measure(phi, plo, prise, shi, slo);
            chk($sformatf("R1 R2 R6 vec%0d pri_hs cycles", v), phi, int'(VECS[v].phi));
            chk($sformatf("R1 R2 vec%0d pri_ls cycles", v), plo, int'(VECS[v].plo));
            chk($sformatf("R2 vec%0d pri rises", v), prise, int'(VECS[v].prise));
            chk($sformatf("R3 R7 vec%0d sec_hs cycles", v), shi, int'(VECS[v].shi));
            chk($sformatf("R3 R4 vec%0d sec_ls cycles", v), slo, int'(VECS[v].slo));
        end

        // R8: phase offset between channels
        stby = 1'b0; pri_en = 1'b1; sec_en = 1'b1;
        pri_duty = DW'(10); sec_duty = DW'(10);
        repeat (3 * P) @(negedge clk);
        wait_pri_rise(seen);
        chk("R8 primary rise seen", int'(seen), 1);
        n = 0;
        for (int i = 0; i < P; i++) begin
            if (sec_hs) break;
            @(negedge clk);
            n++;
        end
        chk("R8 secondary lag", n, H);

        // R9: duty change during a pulse
        wait_pri_rise(seen);
        pri_duty = DW'(16);
        len = 0;
        while (pri_hs && len < P) begin
            len++;
            @(negedge clk);
        end
        chk("R9 pulse keeps old duty", len, 10 - D);
        wait_pri_rise(seen);
        len = 0;
        while (pri_hs && len < P) begin
            len++;
            @(negedge clk);
        end
        chk("R9 next pulse new duty", len, 16 - D);

        // R10: reset during operation
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 reset mid-run", {pri_hs, pri_ls, sec_hs, sec_ls}, 0);
        rst = 1'b0;

        chk("R5 no overlap", ovl, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule